// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver (8 data bits, no parity, 1 stop bit)

This block turns an asynchronous serial line into a stream of bytes with valid/ready flow control. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit; there is no parity. The block runs from a single system clock (125 MHz by default) and offers two line rates, 115200 baud and 4000000 baud. The `baud_fast` input picks the rate and the parameters set the two rates.

The line is first passed through a two-flop synchronizer. A falling edge in the idle state restarts a fractional phase accumulator that produces half-bit ticks. The first tick falls in the middle of the start bit, where the line is checked again. A start bit that is already back high at that point is a runt and is dropped without a trace. The later ticks, taken in pairs, land on the centres of the data bits and the stop bit. Because the accumulator is exact, the sample points do not drift even at 31.25 clocks per bit.

A low stop bit marks the byte with a frame-error user flag. The receiver then refuses to look for a new start until the line has stayed high for a full bit time. A break of any length therefore gives exactly one flagged beat. The output holds one byte. If a new byte completes while the held one is still unaccepted, the new byte is dropped and a sticky overrun flag is raised.

Top module: `uart8n1_rx`

## Requirements
- R1: After reset, `m_valid` and `overrun` are both 0.
- R2: A frame carries bits in the order start (0), data bit 0 through data bit 7, stop. The received byte appears on `m_data` with data bit 0 at `m_data[0]`. This holds at both rates: `baud_fast`=1 selects the fast rate (`BAUD_FAST`, 4000000 by default) and `baud_fast`=0 selects the slow rate (`BAUD_SLOW`, 115200 by default).
- R3: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_user` stay unchanged. After a cycle with `m_valid`=1 and `m_ready`=1 in which no new byte completes, `m_valid` is 0.
- R4: `m_user` is 1 on a beat whose stop bit was sampled low, and 0 on a beat whose stop bit was sampled high.
- R5: A line held low for any length of time yields exactly one beat: data 0x00 with `m_user`=1. No new start bit is accepted until the line has been high for at least one bit time. A high pulse shorter than that, followed by low again, produces no beat.
- R6: A low pulse on the line shorter than half a bit time produces no beat and no error.
- R7: If a byte completes while `m_valid`=1 and `m_ready`=0, that byte is discarded, the held beat is kept, and `overrun` goes to 1. `overrun` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_fast | input | 1 | Rate select: 1 for fast rate, 0 for slow rate; change only while the line is idle |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| m_ready | input | 1 | Downstream accepts the current beat |
| m_valid | output | 1 | A received byte is held on `m_data` |
| m_data | output | 8 | Received byte, first bit on the line at bit 0 |
| m_user | output | 1 | Frame error: the stop bit of this byte was low |
| overrun | output | 1 | Sticky: a byte was lost because the previous one was not accepted |

## Verification
The hardest state to reach from the ports is the recovery wait after a frame error. The case that matters is a line that comes back high for less than a bit and then falls again. A plain receiver would treat that fall as a fresh start and emit a second flagged byte. The bench holds the line low long enough to produce one flagged beat, raises it for a third of a bit, and holds it low again for fifteen bit times. It then counts completed handshakes to show that only the first break produced a beat. A reduced clock-to-baud ratio (1000 clocks per second against 32 and 10 baud) keeps the fractional 31.25-clock bit period while making a sweep of all 256 byte values at the fast rate affordable.

// File: rtl/uart8n1_rx_pkg.sv
package uart8n1_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_RECOVER
  } rx_state_t;

  // One step of the half-bit phase accumulator: result is {tick, next_acc}.
  // The accumulator counts modulo the clock rate and advances by twice the
  // baud rate, so a tick fires every half bit with no long-term drift.
  function automatic logic [32:0] phase_step(input logic [31:0] acc,
                                             input logic [31:0] inc,
                                             input logic [31:0] modulus);
    logic [31:0] sum;
    sum = acc + inc;
    if (sum >= modulus) return {1'b1, sum - modulus};
    return {1'b0, sum};
  endfunction

endpackage

// File: rtl/uart8n1_rx_sync.sv
module uart8n1_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart8n1_rx_phase.sv
module uart8n1_rx_phase
  import uart8n1_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned BAUD_SLOW = 115_200,
  parameter int unsigned BAUD_FAST = 4_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  input  logic restart,
  output logic half_tick
);
  localparam logic [31:0] MODULUS  = 32'(CLK_HZ);
  localparam logic [31:0] INC_SLOW = 32'(2 * BAUD_SLOW);
  localparam logic [31:0] INC_FAST = 32'(2 * BAUD_FAST);

  logic [31:0] acc;
  logic [32:0] step;

  assign step = phase_step(acc, fast ? INC_FAST : INC_SLOW, MODULUS);

  always_ff @(posedge clk) begin
    if (rst || restart) acc <= '0;
    else                acc <= step[31:0];
  end

  assign half_tick = !restart && step[32];
endmodule

// File: rtl/uart8n1_rx_fsm.sv
module uart8n1_rx_fsm
  import uart8n1_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  input  logic       half_tick,
  output logic       restart,
  output logic       byte_done,
  output logic       frame_err,
  output logic [7:0] byte_out,
  output logic       st_idle,
  output logic       st_recover,
  output logic       start_evt,
  output logic       runt_evt
);
  rx_state_t  state;
  logic       phase;    // 0: between centres, 1: next tick is a bit centre
  logic [2:0] bit_idx;
  logic [7:0] shreg;
  logic       hi_seen;  // one half-bit of high line already counted

  assign st_idle    = (state == RX_IDLE);
  assign st_recover = (state == RX_RECOVER);
  assign start_evt  = st_idle && !line;
  assign runt_evt   = (state == RX_START) && half_tick && line;
  assign restart    = start_evt || (st_recover && !line);
  assign byte_done  = (state == RX_STOP) && half_tick && phase;
  assign frame_err  = byte_done && !line;
  assign byte_out   = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      phase   <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      hi_seen <= 1'b0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (!line) state <= RX_START;
        end
        RX_START: begin
          if (half_tick) begin
            if (line) state <= RX_IDLE;
            else begin
              state   <= RX_DATA;
              phase   <= 1'b0;
              bit_idx <= '0;
            end
          end
        end
        RX_DATA: begin
          if (half_tick) begin
            phase <= !phase;
            if (phase) begin
              shreg   <= {line, shreg[7:1]};
              bit_idx <= bit_idx + 3'd1;
              if (bit_idx == 3'd7) state <= RX_STOP;
            end
          end
        end
        RX_STOP: begin
          if (half_tick) begin
            phase <= !phase;
            if (phase) begin
              if (line) state <= RX_IDLE;
              else begin
                state   <= RX_RECOVER;
                hi_seen <= 1'b0;
              end
            end
          end
        end
        RX_RECOVER: begin
          if (!line) hi_seen <= 1'b0;
          else if (half_tick) begin
            if (hi_seen) state <= RX_IDLE;
            else         hi_seen <= 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart8n1_rx_out.sv
module uart8n1_rx_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       uin,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_user,
  output logic       overrun
);
  logic blocked;
  assign blocked = m_valid && !m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_user  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (load && blocked) begin
        overrun <= 1'b1;
      end else if (load) begin
        m_valid <= 1'b1;
        m_data  <= din;
        m_user  <= uin;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart8n1_rx.sv
module uart8n1_rx
  import uart8n1_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned BAUD_SLOW = 115_200,
  parameter int unsigned BAUD_FAST = 4_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_fast,
  input  logic       rx_line,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_user,
  output logic       overrun
);
  logic       line_s;
  logic       half_tick;
  logic       restart;
  logic       byte_done;
  logic       frame_err;
  logic [7:0] byte_val;
  logic       st_idle;
  logic       st_recover;
  logic       start_evt;
  logic       runt_evt;

  uart8n1_rx_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(line_s)
  );

  uart8n1_rx_phase #(
    .CLK_HZ   (CLK_HZ),
    .BAUD_SLOW(BAUD_SLOW),
    .BAUD_FAST(BAUD_FAST)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .fast     (baud_fast),
    .restart  (restart),
    .half_tick(half_tick)
  );

  uart8n1_rx_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .line      (line_s),
    .half_tick (half_tick),
    .restart   (restart),
    .byte_done (byte_done),
    .frame_err (frame_err),
    .byte_out  (byte_val),
    .st_idle   (st_idle),
    .st_recover(st_recover),
    .start_evt (start_evt),
    .runt_evt  (runt_evt)
  );

  uart8n1_rx_out u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (byte_done),
    .din    (byte_val),
    .uin    (frame_err),
    .m_ready(m_ready),
    .m_valid(m_valid),
    .m_data (m_data),
    .m_user (m_user),
    .overrun(overrun)
  );
endmodule

// File: rtl/uart8n1_rx_chk.sv
module uart8n1_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       m_ready,
  input logic       m_valid,
  input logic [7:0] m_data,
  input logic       m_user,
  input logic       overrun,
  input logic       line_s,
  input logic       byte_done,
  input logic       frame_err,
  input logic       st_idle,
  input logic       st_recover,
  input logic       runt_evt
);
  // R1: state right after reset release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!m_valid && !overrun));

  // R3: held beat is stable under backpressure
  p_hold_beat_r3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_user)));

  // R3: accepted beat is released
  p_release_beat_r3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && !byte_done) |=> !m_valid);

  // R4: accepted completion carries the stop-bit verdict
  p_user_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !(m_valid && !m_ready)) |=> (m_valid && (m_user == $past(frame_err))));

  // R5: a low line never ends the recovery wait
  p_recover_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st_recover && !line_s) |=> !st_idle);

  // R6: a runt start returns to idle
  p_runt_idle_r6: assert property (@(posedge clk) disable iff (rst)
    runt_evt |=> st_idle);

  // R7: overrun is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R7: overrun only rises on a blocked completion
  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(byte_done && m_valid && !m_ready));
endmodule

bind uart8n1_rx uart8n1_rx_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .m_ready   (m_ready),
  .m_valid   (m_valid),
  .m_data    (m_data),
  .m_user    (m_user),
  .overrun   (overrun),
  .line_s    (line_s),
  .byte_done (byte_done),
  .frame_err (frame_err),
  .st_idle   (st_idle),
  .st_recover(st_recover),
  .runt_evt  (runt_evt)
);

// File: tb/test_uart8n1_rx.sv
module test_uart8n1_rx;
  localparam int CLK_HZ = 1000;
  localparam int B_SLOW = 10;
  localparam int B_FAST = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       baud_fast = 1'b1;
  logic       rx_line = 1'b1;
  logic       m_ready = 1'b0;
  logic       m_valid;
  logic [7:0] m_data;
  logic       m_user;
  logic       overrun;

  int total = 0;
  int fails = 0;
  int beats = 0;
  logic [7:0] last_data = '0;
  logic       last_user = 1'b0;
  bit done = 1'b0;

  uart8n1_rx #(
    .CLK_HZ(CLK_HZ), .BAUD_SLOW(B_SLOW), .BAUD_FAST(B_FAST)
  ) i_uart8n1_rx (
    .clk(clk), .rst(rst), .baud_fast(baud_fast), .rx_line(rx_line),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .m_user(m_user), .overrun(overrun)
  );

  always @(posedge clk) begin
    if (!rst && m_valid && m_ready) begin
      beats = beats + 1;
      last_data = m_data;
      last_user = m_user;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int edge_at(input int k);
    return (k * CLK_HZ) / (baud_fast ? B_FAST : B_SLOW);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame, then two idle bit times
  task automatic drive_frame(input logic [7:0] b, input bit stop_bit);
    logic [9:0] f;
    f = {stop_bit, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rx_line = f[k];
      wait_cyc(edge_at(k + 1) - edge_at(k));
    end
    rx_line = 1'b1;
    wait_cyc(edge_at(2));
  endtask

  task automatic take(input logic [7:0] d, input bit u, input string req);
    chk(m_valid === 1'b1 && m_data === d && m_user === u, req,
        int'({m_valid, m_user, m_data}), int'({1'b1, u, d}));
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    chk(m_valid === 1'b0, "R3 release", int'(m_valid), 0);
  endtask

  initial begin
    int b0;
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    chk(m_valid === 1'b0, "R1 valid", int'(m_valid), 0);
    chk(overrun === 1'b0, "R1 overrun", int'(overrun), 0);
    wait_cyc(40);

    // R2: every byte value at the fast rate
    baud_fast = 1'b1;
    for (int v = 0; v < 256; v++) begin
      drive_frame(8'(v), 1'b1);
      take(8'(v), 1'b0, "R2 fast sweep");
    end

    // R2: slow rate, walking and mixed patterns
    baud_fast = 1'b0;
    wait_cyc(20);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = (i < 4) ? (8'h01 << (2 * i)) : ((i == 4) ? 8'hA5 : 8'h5A);
      drive_frame(v, 1'b1);
      take(v, 1'b0, "R2 slow");
    end
    baud_fast = 1'b1;
    wait_cyc(20);

    // R3: beat held under backpressure
    drive_frame(8'h96, 1'b1);
    wait_cyc(100);
    chk(m_valid === 1'b1 && m_data === 8'h96, "R3 hold", int'(m_data), 'h96);
    take(8'h96, 1'b0, "R3 after hold");

    // R4: low stop bit flags the beat
    drive_frame(8'h3F, 1'b0);
    take(8'h3F, 1'b1, "R4 frame error");
    drive_frame(8'hC0, 1'b1);
    take(8'hC0, 1'b0, "R4 clean after error");

    // R5: long break gives one beat
    m_ready = 1'b1;
    b0 = beats;
    rx_line = 1'b0;
    wait_cyc(40 * 32);
    rx_line = 1'b1;
    wait_cyc(3 * 32);
    chk(beats - b0 == 1, "R5 break beats", beats - b0, 1);
    chk(last_data === 8'h00 && last_user === 1'b1, "R5 break beat",
        int'({last_user, last_data}), 'h100);

    // R5: short high blip inside recovery does not restart
    b0 = beats;
    rx_line = 1'b0;
    wait_cyc(20 * 32);
    rx_line = 1'b1;
    wait_cyc(10);
    rx_line = 1'b0;
    wait_cyc(15 * 32);
    rx_line = 1'b1;
    wait_cyc(3 * 32);
    chk(beats - b0 == 1, "R5 blip beats", beats - b0, 1);
    m_ready = 1'b0;
    @(negedge clk);
    drive_frame(8'h5C, 1'b1);
    take(8'h5C, 1'b0, "R5 recovery then byte");

    // R6: runt start
    rx_line = 1'b0;
    wait_cyc(6);
    rx_line = 1'b1;
    wait_cyc(12 * 32);
    chk(m_valid === 1'b0, "R6 runt", int'(m_valid), 0);
    drive_frame(8'h81, 1'b1);
    take(8'h81, 1'b0, "R6 byte after runt");

    // R7: overrun
    chk(overrun === 1'b0, "R7 no overrun yet", int'(overrun), 0);
    drive_frame(8'h3C, 1'b1);
    drive_frame(8'hC3, 1'b1);
    chk(overrun === 1'b1, "R7 overrun set", int'(overrun), 1);
    take(8'h3C, 1'b0, "R7 first byte kept");
    wait_cyc(10);
    chk(overrun === 1'b1, "R7 overrun sticky", int'(overrun), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule